// File: doc/BRIEF.md
# System Management Mode Entry/Exit Controller

This block decides when a simple processor core model enters and leaves a system management mode. A request arrives on an active-low, asynchronous pin. The request is edge sensitive. A two-stage synchronizer and a falling-edge detector turn it into a single pending flag. The flag is acted on only when the core signals an instruction boundary, which includes each pass of a repeated string operation, and only while no locked bus sequence is in progress.

Entering the mode starts a state-save handshake. After that the core runs mode code until it executes the resume instruction. A state-restore handshake follows, and the mode ends when the restore completes. The active-low mode indicator is low for the whole span, from the start of the save to the end of the restore. While the mode is active, one further request is remembered and serviced after the exit.

The block also holds the base address register for the mode. A hard reset loads it with a fixed default. A qualified soft reset resets everything else but leaves this register unchanged. A soft reset counts only when its input stays high for a minimum number of clocks.

Top module: `smm_ctrl`

## Requirements
- R1: The request input `smi_n_i` is falling-edge triggered. A high-to-low transition sets the pending flag three rising clock edges after the input is first sampled low. A level that stays low produces no further request.
- R2: A pending request is taken only in a cycle where `insn_bound_i` is 1. The mode is entered at the next rising edge: `smiact_n_o` goes to 0 and `save_req_o` goes to 1. A request that is pending while `insn_bound_i` is 0 waits indefinitely.
- R3: No request is taken in a cycle where `bus_lock_i` is 1, even at an instruction boundary. Entry happens on the first boundary cycle after the lock drops.
- R4: `save_req_o` stays 1 until a cycle with `save_done_i` = 1. It is 0 from the following edge on, and `smiact_n_o` remains 0.
- R5: After `rsm_i` is seen in the mode, `smiact_n_o` stays 0 through the restore phase. It returns to 1 at the edge after `restore_done_i` = 1 and at no other time, except under reset.
- R6: While the mode is active, exactly one further falling edge is remembered. It does not cause re-entry before the resume and restore complete. It is taken at the first qualified boundary after exit, which leaves `smiact_n_o` high for exactly one cycle. Any other edges arriving while a request is already pending are discarded.
- R7: Hard reset (`rst_n` = 0) sets `smiact_n_o` to 1 and `save_req_o` to 0, clears any pending request, and loads `base_o` with the parameter `BASE_RST` (default 32'h0003_0000).
- R8: When `base_we_i` = 1, `base_o` takes `base_wdata_i` at the next edge.
- R9: A soft reset on `soft_rst_i` that is high for at least `SOFT_MIN` (15) consecutive clocks leaves the mode and clears any pending request, but keeps `base_o`. A pulse one clock shorter has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| smi_n_i | input | 1 | Mode request, active low, asynchronous, falling-edge triggered |
| soft_rst_i | input | 1 | Soft reset, active high, asynchronous, qualified by duration |
| insn_bound_i | input | 1 | Instruction boundary or string-iteration strobe |
| bus_lock_i | input | 1 | Locked bus sequence in progress |
| rsm_i | input | 1 | Resume instruction executed |
| save_done_i | input | 1 | State-save sequence complete |
| restore_done_i | input | 1 | Last state-restore cycle complete |
| base_we_i | input | 1 | Load the mode base register |
| base_wdata_i | input | BASE_W | New mode base value |
| smiact_n_o | output | 1 | Mode active, active low |
| save_req_o | output | 1 | Request to run the state-save sequence |
| base_o | output | BASE_W | Mode base register |

## Verification
The assertions assume that the handshake strobes follow the mode's own order. `save_done_i` is raised only while a save is requested, `rsm_i` only while mode code runs, and `restore_done_i` only after a resume. The stimulus keeps all three low at every other time and pulses each for a single cycle at the proper phase. The request and soft-reset pins may be asynchronous, but the bench changes them only on falling clock edges and holds every pulse for at least one full cycle, so the synchronizer always captures it.

// File: rtl/smm_pkg.sv
package smm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAVE    = 2'd1,
        ST_RUN     = 2'd2,
        ST_RESTORE = 2'd3
    } smm_state_e;

    typedef struct packed {
        smm_state_e state;
        logic       pend;
        logic       req_prev;
    } core_regs_t;

endpackage

// File: rtl/smm_sync.sv
module smm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/smm_soft_filter.sv
module smm_soft_filter #(
    parameter int SOFT_MIN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic soft_o
);
    localparam int CW = $clog2(SOFT_MIN + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(SOFT_MIN);
    localparam logic [CW-1:0] CNT_FIRE = CW'(SOFT_MIN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!level_i)               cnt_d = '0;
        else if (cnt_q == CNT_MAX)  cnt_d = cnt_q;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Qualified once the level has been high SOFT_MIN sampled cycles; held while high.
    assign soft_o = level_i && (cnt_q >= CNT_FIRE);
endmodule

// File: rtl/smm_core.sv
module smm_core
    import smm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_i,
    input  logic req_lvl_i,
    input  logic insn_bound_i,
    input  logic bus_lock_i,
    input  logic rsm_i,
    input  logic save_done_i,
    input  logic restore_done_i,
    output logic active_o,
    output logic save_req_o
);
    core_regs_t r_d, r_q;
    logic fall;
    logic take;

    always_comb begin
        r_d      = r_q;
        fall     = r_q.req_prev & ~req_lvl_i;
        take     = 1'b0;
        r_d.req_prev = req_lvl_i;

        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.pend && insn_bound_i && !bus_lock_i) begin
                    take      = 1'b1;
                    r_d.state = ST_SAVE;
                end
            end
            ST_SAVE:    if (save_done_i)    r_d.state = ST_RUN;
            ST_RUN:     if (rsm_i)          r_d.state = ST_RESTORE;
            ST_RESTORE: if (restore_done_i) r_d.state = ST_IDLE;
            default:                        r_d.state = ST_IDLE;
        endcase

        // One pending slot; an edge in the cycle of acceptance refills it.
        if (take) r_d.pend = fall;
        else      r_d.pend = r_q.pend | fall;

        if (soft_i) begin
            r_d.state = ST_IDLE;
            r_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, pend: 1'b0, req_prev: 1'b1};
        else        r_q <= r_d;
    end

    assign active_o   = (r_q.state != ST_IDLE);
    assign save_req_o = (r_q.state == ST_SAVE);

    // R1: the pending flag only rises after the synchronized request went high to low
    a_r1_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.pend) |-> ($past(req_lvl_i) == 1'b0 && $past(r_q.req_prev) == 1'b1));

    // R6: a remembered request survives the whole mode span
    a_r6_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pend && r_q.state != ST_IDLE && !soft_i) |=> r_q.pend);
endmodule

// File: rtl/smm_base_reg.sv
module smm_base_reg #(
    parameter int               BASE_W   = 32,
    parameter logic [BASE_W-1:0] BASE_RST = 32'h0003_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [BASE_W-1:0] wdata_i,
    output logic [BASE_W-1:0] base_o
);
    logic [BASE_W-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (we_i) base_d = wdata_i;
    end

    // Only the hard reset reaches this register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= BASE_RST;
        else        base_q <= base_d;
    end

    assign base_o = base_q;
endmodule

// File: rtl/smm_ctrl.sv
module smm_ctrl #(
    parameter int                BASE_W      = 32,
    parameter logic [BASE_W-1:0] BASE_RST    = 32'h0003_0000,
    parameter int                SOFT_MIN    = 15,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smi_n_i,
    input  logic              soft_rst_i,
    input  logic              insn_bound_i,
    input  logic              bus_lock_i,
    input  logic              rsm_i,
    input  logic              save_done_i,
    input  logic              restore_done_i,
    input  logic              base_we_i,
    input  logic [BASE_W-1:0] base_wdata_i,
    output logic              smiact_n_o,
    output logic              save_req_o,
    output logic [BASE_W-1:0] base_o
);
    logic req_lvl;
    logic soft_lvl;
    logic soft_act;
    logic active;

    smm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .async_i(smi_n_i), .sync_o(req_lvl)
    );

    smm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_soft_sync (
        .clk(clk), .rst_n(rst_n), .async_i(soft_rst_i), .sync_o(soft_lvl)
    );

    smm_soft_filter #(.SOFT_MIN(SOFT_MIN)) u_soft_filter (
        .clk(clk), .rst_n(rst_n), .level_i(soft_lvl), .soft_o(soft_act)
    );

    smm_core u_core (
        .clk(clk), .rst_n(rst_n), .soft_i(soft_act),
        .req_lvl_i(req_lvl), .insn_bound_i(insn_bound_i), .bus_lock_i(bus_lock_i),
        .rsm_i(rsm_i), .save_done_i(save_done_i), .restore_done_i(restore_done_i),
        .active_o(active), .save_req_o(save_req_o)
    );

    smm_base_reg #(.BASE_W(BASE_W), .BASE_RST(BASE_RST)) u_base (
        .clk(clk), .rst_n(rst_n), .we_i(base_we_i), .wdata_i(base_wdata_i), .base_o(base_o)
    );

    assign smiact_n_o = ~active;

    // R2: entry only happens after a boundary strobe
    a_r2_entry_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smiact_n_o) |-> $past(insn_bound_i));

    // R3: entry never splits a locked sequence
    a_r3_no_entry_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smiact_n_o) |-> !$past(bus_lock_i));

    // R4: save request is held until the save handshake
    a_r4_save_held: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req_o && !save_done_i && !soft_act) |=> save_req_o);

    // R5: the indicator releases only after the restore handshake or a soft reset
    a_r5_exit_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smiact_n_o) |-> ($past(restore_done_i) || $past(soft_act)));

    // R9: a soft reset leaves the base register untouched
    a_r9_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_act && !base_we_i) |=> $stable(base_o));
endmodule

// File: tb/smm_ctrl_bench.sv
module smm_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 32;
    localparam logic [BW-1:0] DEF_BASE = 32'h0003_0000;
    localparam logic [BW-1:0] NEW_BASE = 32'h000A_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smi_n = 1'b1, soft_rst = 1'b0, insn = 1'b0, lock = 1'b0;
    logic rsm = 1'b0, save_done = 1'b0, restore_done = 1'b0, we = 1'b0;
    logic [BW-1:0] wdata = '0;
    logic smiact_n, save_req;
    logic [BW-1:0] base;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int exp_q[$];
    logic prev_act_n = 1'b1;

    smm_ctrl u_smm_ctrl (
        .clk(clk), .rst_n(rst_n), .smi_n_i(smi_n), .soft_rst_i(soft_rst),
        .insn_bound_i(insn), .bus_lock_i(lock), .rsm_i(rsm),
        .save_done_i(save_done), .restore_done_i(restore_done),
        .base_we_i(we), .base_wdata_i(wdata),
        .smiact_n_o(smiact_n), .save_req_o(save_req), .base_o(base)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: each mode entry must match the next expected entry cycle.
    always @(negedge clk) begin
        if (rst_n && prev_act_n && !smiact_n) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1/R6 unexpected entry", 64'(cyc), 64'hFFFF_FFFF);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(cyc == e, "R2 entry cycle", 64'(cyc), 64'(e));
            end
        end
        prev_act_n = smiact_n;
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_smi();
        smi_n = 1'b0; tick(1); smi_n = 1'b1;
    endtask

    task automatic do_save();
        save_done = 1'b1; tick(1); save_done = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        // R7 reset state
        chk(smiact_n == 1'b1, "R7 smiact after reset", 64'(smiact_n), 64'd1);
        chk(save_req == 1'b0, "R7 save_req after reset", 64'(save_req), 64'd0);
        chk(base == DEF_BASE, "R7 base default", 64'(base), 64'(DEF_BASE));

        // R8 base write
        we = 1'b1; wdata = NEW_BASE; tick(1); we = 1'b0;
        chk(base == NEW_BASE, "R8 base write", 64'(base), 64'(NEW_BASE));

        // R2 request waits for a boundary
        smi_n = 1'b0;
        tick(8);
        chk(smiact_n == 1'b1, "R2 no entry without boundary", 64'(smiact_n), 64'd1);
        insn = 1'b1; exp_q.push_back(cyc + 1); tick(1); insn = 1'b0;
        chk(save_req == 1'b1, "R4 save_req on entry", 64'(save_req), 64'd1);
        tick(3);
        chk(save_req == 1'b1, "R4 save_req held", 64'(save_req), 64'd1);
        do_save();
        chk(save_req == 1'b0, "R4 save_req after done", 64'(save_req), 64'd0);
        chk(smiact_n == 1'b0, "R4 still in mode", 64'(smiact_n), 64'd0);

        // R5 restore phase keeps the indicator low
        rsm = 1'b1; tick(1); rsm = 1'b0;
        tick(3);
        chk(smiact_n == 1'b0, "R5 low during restore", 64'(smiact_n), 64'd0);
        restore_done = 1'b1; tick(1); restore_done = 1'b0;
        chk(smiact_n == 1'b1, "R5 exit after restore", 64'(smiact_n), 64'd1);

        // R1 steady low level is not a new request
        insn = 1'b1; tick(6);
        chk(smiact_n == 1'b1, "R1 level ignored", 64'(smiact_n), 64'd1);
        insn = 1'b0; smi_n = 1'b1; tick(3);

        // R3 locked sequence blocks entry
        lock = 1'b1; insn = 1'b1;
        pulse_smi();
        tick(8);
        chk(smiact_n == 1'b1, "R3 no entry while locked", 64'(smiact_n), 64'd1);
        lock = 1'b0; exp_q.push_back(cyc + 1); tick(1); insn = 1'b0;
        chk(smiact_n == 1'b0, "R3 entry after unlock", 64'(smiact_n), 64'd0);
        do_save();

        // R6 nested request held, extra one dropped
        pulse_smi(); tick(4);
        pulse_smi(); tick(4);
        insn = 1'b1; tick(5);
        chk(smiact_n == 1'b0, "R6 no re-entry before resume", 64'(smiact_n), 64'd0);
        chk(save_req == 1'b0, "R6 no second save in mode", 64'(save_req), 64'd0);
        rsm = 1'b1; tick(1); rsm = 1'b0; tick(2);
        restore_done = 1'b1; exp_q.push_back(cyc + 2); tick(1); restore_done = 1'b0;
        chk(smiact_n == 1'b1, "R6 one idle cycle between", 64'(smiact_n), 64'd1);
        tick(1);
        chk(save_req == 1'b1, "R6 nested request serviced", 64'(save_req), 64'd1);
        do_save();
        rsm = 1'b1; tick(1); rsm = 1'b0; tick(1);
        restore_done = 1'b1; tick(1); restore_done = 1'b0;
        tick(10);
        chk(smiact_n == 1'b1, "R6 extra edge dropped", 64'(smiact_n), 64'd1);
        insn = 1'b0;

        // R9 soft reset qualification
        insn = 1'b1; smi_n = 1'b0; exp_q.push_back(cyc + 4); tick(1); smi_n = 1'b1;
        tick(4); insn = 1'b0;
        do_save();
        pulse_smi(); tick(4);
        soft_rst = 1'b1; tick(14); soft_rst = 1'b0; tick(6);
        chk(smiact_n == 1'b0, "R9 short soft pulse ignored", 64'(smiact_n), 64'd0);
        soft_rst = 1'b1; tick(15); soft_rst = 1'b0; tick(6);
        chk(smiact_n == 1'b1, "R9 soft reset exits mode", 64'(smiact_n), 64'd1);
        chk(save_req == 1'b0, "R9 soft reset clears save_req", 64'(save_req), 64'd0);
        chk(base == NEW_BASE, "R9 base kept", 64'(base), 64'(NEW_BASE));
        insn = 1'b1; tick(8);
        chk(smiact_n == 1'b1, "R9 pending cleared", 64'(smiact_n), 64'd1);
        insn = 1'b0;

        // R7 hard reset clears pending and restores base
        pulse_smi(); tick(5);
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);
        chk(base == DEF_BASE, "R7 base after hard reset", 64'(base), 64'(DEF_BASE));
        insn = 1'b1; tick(6);
        chk(smiact_n == 1'b1, "R7 pending cleared by reset", 64'(smiact_n), 64'd1);
        insn = 1'b0; tick(2);

        chk(exp_q.size() == 0, "R2 all expected entries seen", 64'(exp_q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule